// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control sequencer of a small 16-bit two-operand processor whose memory port completes one access per clock. An external decoder describes each instruction with a few flags: how many extension words follow the opcode, whether the source and the destination live in memory, and whether the instruction is a compare, a push, a call, or a write to the program counter. The sequencer turns those flags into a train of cycles. For each cycle it drives a memory read strobe, a memory write strobe, a program-counter advance (by one 16-bit word), a phase code and, in the final cycle, a done pulse.

The instruction's length in cycles is built from its memory traffic plus fixed penalties. The opcode fetch and each extension word cost one read cycle and advance the program counter. Each memory-resident operand costs one read cycle; a memory destination is read and then stored. Control-flow and stack operations add execute cycles with no memory traffic. A memory result takes one store cycle, and a compare keeps that cycle with its write strobe held low. Decoding overlaps the opcode fetch, so there is no decode cycle.

A new instruction is taken on a clock edge where `start_i` is high and `accept_o` is high. `accept_o` is high when the sequencer is idle or in the last cycle of the current instruction. The opcode fetch of the new instruction follows in the next cycle, so back-to-back instructions leave no gap.

Top module: `instr_cycle_seq`

## Requirements
- R1: After reset, and whenever no instruction is in progress, `phase_o` is 0 (idle), `mem_rd_o`, `mem_wr_o`, `pc_inc_o` and `done_o` are low, and `accept_o` is high.
- R2: The cycle after an instruction is accepted is its opcode fetch: `phase_o` = 1, with `mem_rd_o` and `pc_inc_o` high.
- R3: Each extension word adds one cycle with `phase_o` = 2, `mem_rd_o` and `pc_inc_o` high. A count on `ext_words_i` above MAX_EXT (default 2) is treated as MAX_EXT.
- R4: The operand read phase lasts `src_mem_i` + `dst_mem_i` cycles. In these cycles `phase_o` = 3, `mem_rd_o` is high and `pc_inc_o` is low.
- R5: The extra execute phase lasts two cycles for a call. Otherwise it lasts `is_push_i` + `wr_pc_i` cycles. In these cycles `phase_o` = 4 and no memory or PC strobe is active.
- R6: A store cycle (`phase_o` = 5) occurs once when `dst_mem_i`, `is_push_i` or `is_call_i` is set. `mem_wr_o` is high in it unless `is_cmp_i` is set, in which case the cycle is still spent with `mem_wr_o` low. `mem_rd_o` and `mem_wr_o` are never high together.
- R7: Phases run in the fixed order fetch, extension, operand read, execute, store. Phases with a zero count are skipped.
- R8: `done_o` is high in exactly the last cycle of each instruction. The count from fetch to done reproduces these totals: register add 1, immediate-to-register add 2, memory-to-register add 3, register-to-memory add 4, memory-to-memory add 6, jump 2, pop into PC 3, push register 3, immediate push 4, immediate call 5.
- R9: `start_i` is ignored while `accept_o` is low. The running instruction keeps its cycle train, and no extra instruction follows.
- R10: When `start_i` is high in the `done_o` cycle, the next cycle is the opcode fetch of the new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin a new instruction |
| ext_words_i | input | EXT_W | Number of extension words |
| src_mem_i | input | 1 | Source operand is in memory |
| dst_mem_i | input | 1 | Destination operand is in memory |
| is_cmp_i | input | 1 | Instruction is a compare |
| is_push_i | input | 1 | Instruction is a push |
| is_call_i | input | 1 | Instruction is a call |
| wr_pc_i | input | 1 | Instruction writes the program counter |
| accept_o | output | 1 | A start is taken on the next edge |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| pc_inc_o | output | 1 | Advance the program counter by one word |
| phase_o | output | 3 | Phase code: 0 idle, 1 fetch, 2 extension, 3 operand read, 4 execute, 5 store |
| done_o | output | 1 | Last cycle of the instruction |

## Verification
Two events can share one cycle: the completion of one instruction (`done_o`) and the acceptance of the next. For a one-cycle register instruction, the fetch and the done pulse also coincide. The bench drives instructions back to back with `start_i` held high, including runs of one-cycle instructions, and also drives requests with changed flags while the sequencer is busy. A behavioural cycle model checks each cycle that a request in the done cycle yields a fetch in the next cycle with no gap. It also checks that requests made while busy leave the running cycle train unchanged.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FETCH = 3'd1,
    PH_EXT   = 3'd2,
    PH_OPRD  = 3'd3,
    PH_EXEC  = 3'd4,
    PH_STORE = 3'd5
  } phase_e;

  // number of counted phases after the opcode fetch
  localparam int unsigned NUM_TAIL = 4;
  // code of the first counted phase
  localparam int unsigned TAIL_BASE = 2;
endpackage

// File: rtl/isq_budget.sv
module isq_budget #(
  parameter int unsigned MAX_EXT = 2,
  parameter int unsigned EXT_W   = 2,
  parameter int unsigned CNT_W   = 2
) (
  input  logic [EXT_W-1:0]               ext_words_i,
  input  logic                           src_mem_i,
  input  logic                           dst_mem_i,
  input  logic                           is_cmp_i,
  input  logic                           is_push_i,
  input  logic                           is_call_i,
  input  logic                           wr_pc_i,
  output logic [isq_pkg::NUM_TAIL-1:0][CNT_W-1:0] budget_o,
  output logic                           wr_en_o
);
  localparam logic [CNT_W-1:0] EXT_CAP = CNT_W'(MAX_EXT);

  logic [CNT_W-1:0] ext_cnt, rd_cnt, exe_cnt, st_cnt;
  logic             stack_pen, flow_pen;

  always_comb begin
    if (CNT_W'(ext_words_i) > EXT_CAP) ext_cnt = EXT_CAP;
    else                               ext_cnt = CNT_W'(ext_words_i);
    rd_cnt    = CNT_W'(src_mem_i) + CNT_W'(dst_mem_i);
    stack_pen = is_push_i | is_call_i;
    flow_pen  = wr_pc_i | is_call_i;
    exe_cnt   = CNT_W'(stack_pen) + CNT_W'(flow_pen);
    st_cnt    = CNT_W'(dst_mem_i | is_push_i | is_call_i);
  end

  assign budget_o = {st_cnt, exe_cnt, rd_cnt, ext_cnt};
  assign wr_en_o  = ~is_cmp_i;
endmodule

// File: rtl/isq_fsm.sv
module isq_fsm #(
  parameter int unsigned CNT_W = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start_i,
  input  logic [isq_pkg::NUM_TAIL-1:0][CNT_W-1:0] budget_i,
  input  logic                                    wr_en_i,
  output isq_pkg::phase_e                         phase_o,
  output logic                                    done_o,
  output logic                                    accept_o,
  output logic                                    wr_en_o
);
  import isq_pkg::*;

  phase_e                             ph_q, ph_d;
  logic [CNT_W-1:0]                   rem_q, rem_d;
  logic [NUM_TAIL-1:0][CNT_W-1:0]     plan_q;
  logic                               wr_en_q;
  logic                               busy, last, take, found, step_en;
  phase_e                             nxt_ph;
  logic [CNT_W-1:0]                   nxt_cnt;

  // search for the nearest later phase with a nonzero count
  always_comb begin
    found   = 1'b0;
    nxt_ph  = PH_IDLE;
    nxt_cnt = '0;
    for (int i = NUM_TAIL - 1; i >= 0; i--) begin
      if ((i + TAIL_BASE) > int'(ph_q) && plan_q[i] != '0) begin
        found   = 1'b1;
        nxt_ph  = phase_e'(i + TAIL_BASE);
        nxt_cnt = plan_q[i];
      end
    end
  end

  assign busy     = (ph_q != PH_IDLE);
  assign last     = busy && (rem_q == '0) && !found;
  assign accept_o = !busy || last;
  assign take     = start_i && accept_o;
  assign step_en  = take || busy;

  always_comb begin
    ph_d  = ph_q;
    rem_d = rem_q;
    if (take) begin
      ph_d  = PH_FETCH;
      rem_d = '0;
    end else if (busy) begin
      if (rem_q != '0) begin
        rem_d = rem_q - 1'b1;
      end else if (found) begin
        ph_d  = nxt_ph;
        rem_d = nxt_cnt - 1'b1;
      end else begin
        ph_d  = PH_IDLE;
        rem_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      rem_q <= '0;
    end else if (step_en) begin
      ph_q  <= ph_d;
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plan_q  <= '0;
      wr_en_q <= 1'b0;
    end else if (take) begin
      plan_q  <= budget_i;
      wr_en_q <= wr_en_i;
    end
  end

  assign phase_o = ph_q;
  assign done_o  = last;
  assign wr_en_o = wr_en_q;

  assert_done_then_idle_or_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (ph_q == PH_IDLE || ph_q == PH_FETCH));

  assert_phase_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_o) |=> (ph_q != PH_IDLE && ph_q >= $past(ph_q)));

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !accept_o) |=> ($stable(plan_q) && $stable(wr_en_q)));

  assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> (ph_q == PH_FETCH));

  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i) |=> (ph_q == PH_FETCH));
endmodule

// File: rtl/isq_strobe.sv
module isq_strobe (
  input  logic            clk,
  input  logic            rst_n,
  input  isq_pkg::phase_e phase_i,
  input  logic            wr_en_i,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            pc_inc_o
);
  import isq_pkg::*;

  always_comb begin
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    pc_inc_o = 1'b0;
    unique case (phase_i)
      PH_FETCH, PH_EXT: begin
        mem_rd_o = 1'b1;
        pc_inc_o = 1'b1;
      end
      PH_OPRD:  mem_rd_o = 1'b1;
      PH_STORE: mem_wr_o = wr_en_i;
      default: ;
    endcase
  end

  assert_rd_wr_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  assert_pc_only_on_word_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc_o |-> mem_rd_o);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_IDLE) |-> !(mem_rd_o || mem_wr_o || pc_inc_o));

  assert_exec_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_EXEC) |-> $countones({mem_rd_o, mem_wr_o, pc_inc_o}) == 0);
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq #(
  parameter int unsigned MAX_EXT = 2,
  parameter int unsigned EXT_W   = $clog2(MAX_EXT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [EXT_W-1:0] ext_words_i,
  input  logic             src_mem_i,
  input  logic             dst_mem_i,
  input  logic             is_cmp_i,
  input  logic             is_push_i,
  input  logic             is_call_i,
  input  logic             wr_pc_i,
  output logic             accept_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             pc_inc_o,
  output logic [2:0]       phase_o,
  output logic             done_o
);
  import isq_pkg::*;

  localparam int unsigned MAX_CNT = (MAX_EXT > 2) ? MAX_EXT : 2;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  logic                           rst_meta_q, rst_sync_q;
  logic [NUM_TAIL-1:0][CNT_W-1:0] budget;
  logic                           wr_en_in, wr_en_q;
  phase_e                         phase;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  isq_budget #(.MAX_EXT(MAX_EXT), .EXT_W(EXT_W), .CNT_W(CNT_W)) u_budget (
    .ext_words_i (ext_words_i),
    .src_mem_i   (src_mem_i),
    .dst_mem_i   (dst_mem_i),
    .is_cmp_i    (is_cmp_i),
    .is_push_i   (is_push_i),
    .is_call_i   (is_call_i),
    .wr_pc_i     (wr_pc_i),
    .budget_o    (budget),
    .wr_en_o     (wr_en_in)
  );

  isq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start_i  (start_i),
    .budget_i (budget),
    .wr_en_i  (wr_en_in),
    .phase_o  (phase),
    .done_o   (done_o),
    .accept_o (accept_o),
    .wr_en_o  (wr_en_q)
  );

  isq_strobe u_strobe (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .phase_i  (phase),
    .wr_en_i  (wr_en_q),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .pc_inc_o (pc_inc_o)
  );

  assign phase_o = phase;
endmodule

// File: tb/instr_cycle_seq_bench.sv
module instr_cycle_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] ext_words_i;
  logic       src_mem_i, dst_mem_i, is_cmp_i, is_push_i, is_call_i, wr_pc_i;
  logic       accept_o, mem_rd_o, mem_wr_o, pc_inc_o, done_o;
  logic [2:0] phase_o;

  int n_checks = 0;
  int n_fails  = 0;
  int run_len  = 0;
  bit finished = 1'b0;

  // expected record: [6] done, [5] wr, [4] rd, [3] pc, [2:0] phase
  logic [6:0] exp_q[$];
  int         tot_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_cycle_seq u_instr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_words_i(ext_words_i),
    .src_mem_i(src_mem_i), .dst_mem_i(dst_mem_i), .is_cmp_i(is_cmp_i),
    .is_push_i(is_push_i), .is_call_i(is_call_i), .wr_pc_i(wr_pc_i),
    .accept_o(accept_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .pc_inc_o(pc_inc_o), .phase_o(phase_o), .done_o(done_o)
  );

  function automatic string req_of(input logic [2:0] ph);
    case (ph)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R1";
    endcase
  endfunction

  // at: {ext[1:0], src, dst, cmp, push, call, wpc}
  task automatic build(input logic [7:0] at, input int tot);
    int ext = int'(at[7:6]);
    int rd  = int'(at[5]) + int'(at[4]);
    int exe;
    int st  = (at[4] || at[2] || at[1]) ? 1 : 0;
    logic [6:0] recs[$];
    if (ext > 2) ext = 2;
    exe = at[1] ? 2 : int'(at[2]) + int'(at[0]);
    recs.push_back({1'b0, 1'b0, 1'b1, 1'b1, 3'd1});
    for (int i = 0; i < ext; i++) recs.push_back({1'b0, 1'b0, 1'b1, 1'b1, 3'd2});
    for (int i = 0; i < rd; i++)  recs.push_back({1'b0, 1'b0, 1'b1, 1'b0, 3'd3});
    for (int i = 0; i < exe; i++) recs.push_back({1'b0, 1'b0, 1'b0, 1'b0, 3'd4});
    for (int i = 0; i < st; i++)  recs.push_back({1'b0, !at[3], 1'b0, 1'b0, 3'd5});
    recs[recs.size()-1][6] = 1'b1;
    foreach (recs[i]) exp_q.push_back(recs[i]);
    tot_q.push_back(tot);
  endtask

  task automatic step(input logic st, input logic [7:0] at, input int tot, output logic acc);
    logic [6:0] e, got;
    logic       exp_acc;
    @(negedge clk);
    e       = (exp_q.size() != 0) ? exp_q[0] : 7'd0;
    exp_acc = (exp_q.size() == 0) || exp_q[0][6];
    got     = {done_o, mem_wr_o, mem_rd_o, pc_inc_o, phase_o};
    n_checks++;
    if (got !== e) begin
      n_fails++;
      $display("FAIL %s cycle outputs {done,wr,rd,pc,phase}: actual %b expected %b",
               (got[6] !== e[6]) ? "R8" : req_of(e[2:0]), got, e);
    end
    n_checks++;
    if (accept_o !== exp_acc) begin
      n_fails++;
      $display("FAIL R9 accept_o: actual %b expected %b", accept_o, exp_acc);
    end
    if (phase_o == 3'd1) run_len = 1;
    else if (phase_o != 3'd0) run_len++;
    if (done_o === 1'b1 && tot_q.size() != 0) begin
      n_checks++;
      if (run_len != tot_q[0]) begin
        n_fails++;
        $display("FAIL R8 cycles fetch-to-done: actual %0d expected %0d", run_len, tot_q[0]);
      end
      void'(tot_q.pop_front());
    end
    if (exp_q.size() != 0) void'(exp_q.pop_front());
    start_i = st;
    {ext_words_i, src_mem_i, dst_mem_i, is_cmp_i, is_push_i, is_call_i, wr_pc_i} = at;
    acc = st && exp_acc;
    if (acc) build(at, tot);
  endtask

  task automatic issue(input logic [7:0] at, input int tot);
    logic acc = 1'b0;
    while (!acc) step(1'b1, at, tot, acc);
  endtask

  task automatic drain();
    logic acc;
    while (exp_q.size() != 0) step(1'b0, 8'h00, 0, acc);
    step(1'b0, 8'h00, 0, acc);
    step(1'b0, 8'h00, 0, acc);
  endtask

  // instruction forms with their expected totals (R8)
  localparam logic [7:0] ADD_RR = 8'b00_000000;
  localparam logic [7:0] ADD_AR = 8'b01_100000;
  localparam logic [7:0] ADD_IR = 8'b01_000000;
  localparam logic [7:0] ADD_RM = 8'b01_010000;
  localparam logic [7:0] ADD_MM = 8'b10_110000;
  localparam logic [7:0] CMP_MR = 8'b01_101000;
  localparam logic [7:0] CMP_MM = 8'b10_111000;
  localparam logic [7:0] JMP    = 8'b00_000001;
  localparam logic [7:0] POP_PC = 8'b00_100001;
  localparam logic [7:0] POP_R  = 8'b00_100000;
  localparam logic [7:0] PUSH_R = 8'b00_000100;
  localparam logic [7:0] PUSH_I = 8'b01_000100;
  localparam logic [7:0] CALL_I = 8'b01_000010;
  localparam logic [7:0] EXT_OV = 8'b11_000000;

  initial begin
    logic acc;
    rst_n = 1'b0;
    start_i = 1'b0;
    {ext_words_i, src_mem_i, dst_mem_i, is_cmp_i, is_push_i, is_call_i, wr_pc_i} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs through and after reset release
    repeat (5) step(1'b0, 8'h00, 0, acc);

    // each form alone, separated by idle cycles (R2..R8)
    issue(ADD_RR, 1); drain();
    issue(ADD_IR, 2); drain();
    issue(ADD_AR, 3); drain();
    issue(ADD_RM, 4); drain();
    issue(ADD_MM, 6); drain();
    issue(CMP_MR, 3); drain();
    issue(CMP_MM, 6); drain();   // R6: store cycle kept, write low
    issue(JMP, 2);    drain();
    issue(POP_PC, 3); drain();
    issue(POP_R, 2);  drain();
    issue(PUSH_R, 3); drain();
    issue(PUSH_I, 4); drain();
    issue(CALL_I, 5); drain();
    issue(EXT_OV, 3); drain();   // R3: extension count capped at 2

    // R10: back-to-back, including runs of one-cycle instructions
    issue(ADD_RR, 1); issue(ADD_RR, 1); issue(ADD_RR, 1);
    issue(ADD_MM, 6); issue(ADD_RR, 1); issue(CALL_I, 5);
    issue(CMP_MM, 6); issue(JMP, 2); issue(PUSH_I, 4);
    drain();

    // R9: requests with other flags while busy are ignored
    issue(ADD_MM, 6);
    repeat (3) step(1'b1, CALL_I, 5, acc);
    step(1'b0, 8'h00, 0, acc);
    step(1'b1, PUSH_R, 3, acc);
    drain();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule